// File: doc/BRIEF.md
# Two-Wire Register Slave with Indexed and Block Access

This block is the serial configuration port of a larger chip. A host on a two-wire bus reaches a small array of 8-bit registers through it. The block samples the bus clock and data lines with the system clock and detects start, repeated start and stop conditions. It acknowledges only its own 7-bit address and then decodes a command byte. The top bit of the command chooses between two kinds of access. Indexed access starts at the offset held in the low seven bits. Block access always starts at register 0 and carries a byte count first. Byte and word transfers are both indexed: a word is the low byte at the offset followed by the high byte at offset+1.

The register file sits outside the block. For each write, the block gives a one-cycle strobe that selects one register and an 8-bit data value. For reads, it gives a read index and takes the register value back on `rd_data`. Offsets flagged as read-only in a parameter mask are acknowledged but never strobed. The data line is open-drain: `sda_oe` high means the line is pulled low.

The controller has ten named states. IDLE waits for a start. ADDR shifts in the address byte. On a match it goes to ADDR_ACK, and otherwise to IGNORE. ADDR_ACK goes to CMD on a write address and to RDATA on a read address. CMD goes to CMD_ACK when the command is valid, and to IGNORE when a block command has nonzero offset bits. CMD_ACK and WDATA_ACK both go to WDATA. WDATA goes to WDATA_ACK after eight bits. RDATA goes to RDATA_ACK after eight bits. RDATA_ACK goes back to RDATA when the host acknowledges, and to IGNORE when it does not. From any state, a start goes to ADDR and a stop goes to IDLE.

Top module: `smb_reg_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe` = 0) and no write strobe is active.
- R2: The slave acknowledges an address byte whose upper seven bits equal `SLV_ADDR`. For any other address it never drives the data line until the next start, and the rest of the transfer causes no strobes.
- R3: In the command byte, bit 7 = 1 selects indexed access at offset bits 6:0. Bit 7 = 0 selects block access and is acknowledged only when bits 6:0 are zero. A block command with any nonzero offset bit is not acknowledged, and the rest of the transfer is ignored.
- R4: In an indexed write, each data byte is acknowledged. At that acknowledge, exactly one strobe pulses for the current register with the received byte, shifted in most significant bit first.
- R5: A word write stores the first data byte at the offset and the second at offset+1.
- R6: In a block write, the first byte after the command is the count. It is acknowledged and not stored. Later bytes go to registers 0, 1, 2 and so on in order, and a stop after any complete byte ends the transfer.
- R7: After a command, a repeated start and the read address, the slave sends the register at the offset, most significant bit first.
- R8: A word read returns the register at the offset and then the one at offset+1, provided the host acknowledges the first byte.
- R9: A block read first sends the count `NREG` (18), then registers from 0 upward while the host acknowledges. After a host NACK the slave releases the line.
- R10: Writes to offsets set in `RO_MASK` (by default offsets 5 and 8) are acknowledged but cause no strobe.
- R11: Offsets at or above `NREG` are acknowledged on write without a strobe, and read back as 8'hFF.
- R12: A start in any state restarts the address phase, and a stop in any state returns the slave to IDLE.
- R13: The slave changes `sda_oe` only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | High pulls the data line low |
| rd_idx | output | 5 | Register index whose value is wanted on rd_data |
| rd_data | input | 8 | Value of register rd_idx |
| wr_stb | output | NREG | One-cycle write strobe, one bit per register |
| wr_data | output | 8 | Byte to store with the active strobe |

## Verification
A wrong bit counter or a wrong state shows up within one bit time at the ports. An acknowledge lands on the wrong clock pulse, or a read byte is shifted by a bit position. A stale pointer or a lost count phase shows up as a strobe on the wrong register, or as a read byte taken from a neighbouring offset. Both appear at the first strobe or the first returned byte after the fault. A failure to reset state on a start or stop shows up on the next transfer, as a missing acknowledge on the address byte.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } smb_state_e;

    // Bus events seen in the system clock domain
    typedef struct packed {
        logic scl;    // synchronised clock level
        logic sda;    // synchronised data level
        logic rise;   // clock went high
        logic fall;   // clock went low
        logic start;  // data fell while clock high
        logic stop;   // data rose while clock high
    } smb_evt_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output smb_evt_t evt
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    // Idle bus is high, so reset to ones to avoid a false start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign evt.scl   = scl_s;
    assign evt.sda   = sda_s;
    assign evt.rise  = scl_s & ~scl_q;
    assign evt.fall  = ~scl_s & scl_q;
    assign evt.start = scl_s & scl_q & sda_q & ~sda_s;
    assign evt.stop  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
    import smb_pkg::*;
#(
    parameter int              NREG     = 18,
    parameter logic [6:0]      SLV_ADDR = 7'h69,
    parameter logic [NREG-1:0] RO_MASK  = 'h120,
    localparam int             IDXW     = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  smb_evt_t        evt,
    output logic            sda_oe,
    output logic [IDXW-1:0] rd_idx,
    input  logic [7:0]      rd_data,
    output logic [NREG-1:0] wr_stb,
    output logic [7:0]      wr_data
);

    localparam logic [7:0] NREG_B = 8'(NREG);

    smb_state_e      state;
    logic [3:0]      bit_cnt;
    logic [7:0]      rx_sr;
    logic [7:0]      tx_sr;
    logic [7:0]      ptr;
    logic            cnt_phase;   // next byte is the block count
    logic            is_read;
    logic            m_ack;
    logic            stb_pulse;
    logic [IDXW-1:0] stb_idx;
    logic [7:0]      stb_data;

    logic            in_range;
    logic [IDXW-1:0] ptr_idx;
    logic [NREG-1:0] ro_shift;
    logic            wr_ok;
    logic [7:0]      ptr_next;
    logic [7:0]      load_byte;
    logic            rx_bit;
    logic            rx_done;

    assign in_range  = (ptr < NREG_B);
    assign ptr_idx   = ptr[IDXW-1:0];
    assign ro_shift  = RO_MASK >> ptr_idx;
    assign wr_ok     = in_range && !ro_shift[0];
    assign ptr_next  = (ptr == 8'hFF) ? ptr : ptr + 8'd1;
    assign load_byte = cnt_phase ? NREG_B : (in_range ? rd_data : 8'hFF);
    assign rd_idx    = in_range ? ptr_idx : '0;
    assign rx_bit    = evt.rise && (bit_cnt != 4'd8);
    assign rx_done   = evt.fall && (bit_cnt == 4'd8);

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '1;
            ptr       <= '0;
            cnt_phase <= 1'b0;
            is_read   <= 1'b0;
            m_ack     <= 1'b0;
            stb_pulse <= 1'b0;
            stb_idx   <= '0;
            stb_data  <= '0;
        end else begin
            stb_pulse <= 1'b0;
            if (evt.start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
            end else if (evt.stop) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE, ST_IGNORE: ;
                    ST_ADDR: begin
                        if (rx_bit) begin
                            rx_sr   <= {rx_sr[6:0], evt.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (rx_done) begin
                            bit_cnt <= '0;
                            if (rx_sr[7:1] == SLV_ADDR) begin
                                state   <= ST_ADDR_ACK;
                                is_read <= rx_sr[0];
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_CMD: begin
                        if (rx_bit) begin
                            rx_sr   <= {rx_sr[6:0], evt.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (rx_done) begin
                            bit_cnt <= '0;
                            if (rx_sr[7] || (rx_sr[6:0] == 7'd0)) begin
                                state     <= ST_CMD_ACK;
                                ptr       <= rx_sr[7] ? {1'b0, rx_sr[6:0]} : 8'd0;
                                cnt_phase <= ~rx_sr[7];
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (rx_bit) begin
                            rx_sr   <= {rx_sr[6:0], evt.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (rx_done) begin
                            bit_cnt <= '0;
                            state   <= ST_WDATA_ACK;
                            if (cnt_phase) begin
                                cnt_phase <= 1'b0;
                            end else begin
                                stb_pulse <= wr_ok;
                                stb_idx   <= ptr_idx;
                                stb_data  <= rx_sr;
                                ptr       <= ptr_next;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.fall) begin
                            if (is_read) begin
                                state <= ST_RDATA;
                                tx_sr <= load_byte;
                                if (cnt_phase) cnt_phase <= 1'b0;
                                else           ptr       <= ptr_next;
                            end else begin
                                state <= ST_CMD;
                            end
                        end
                    end
                    ST_CMD_ACK, ST_WDATA_ACK: begin
                        if (evt.fall) state <= ST_WDATA;
                    end
                    ST_RDATA: begin
                        if (evt.fall) begin
                            if (bit_cnt == 4'd7) begin
                                state   <= ST_RDATA_ACK;
                                bit_cnt <= '0;
                            end else begin
                                tx_sr   <= {tx_sr[6:0], 1'b1};
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_RDATA_ACK: begin
                        if (evt.rise) begin
                            m_ack <= ~evt.sda;
                        end else if (evt.fall) begin
                            if (m_ack) begin
                                state <= ST_RDATA;
                                tx_sr <= load_byte;
                                if (cnt_phase) cnt_phase <= 1'b0;
                                else           ptr       <= ptr_next;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~tx_sr[7];
            default:                               sda_oe = 1'b0;
        endcase
    end

    for (genvar g = 0; g < NREG; g++) begin : g_stb
        assign wr_stb[g] = stb_pulse && (stb_idx == IDXW'(g));
    end
    assign wr_data = stb_data;

    p_onehot_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb))
        else $error("more than one write strobe");

    p_strobe_at_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb != '0) |-> (state == ST_WDATA_ACK && sda_oe))
        else $error("strobe outside data acknowledge");

    p_ro_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb & RO_MASK) == '0)
        else $error("read-only register strobed");

    p_ignore_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> (!sda_oe && wr_stb == '0))
        else $error("line driven while ignoring");

    p_start_restarts_r12: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> (state == ST_ADDR && bit_cnt == 4'd0))
        else $error("start did not restart address phase");

    p_stop_idles_r12: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> (state == ST_IDLE))
        else $error("stop did not return to idle");

    p_sda_low_clock_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !evt.scl)
        else $error("data line changed while clock high");

endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
    import smb_pkg::*;
#(
    parameter int              NREG        = 18,
    parameter logic [6:0]      SLV_ADDR    = 7'h69,
    parameter logic [NREG-1:0] RO_MASK     = 'h120,
    parameter int              SYNC_STAGES = 2,
    localparam int             IDXW        = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_oe,
    output logic [IDXW-1:0] rd_idx,
    input  logic [7:0]      rd_data,
    output logic [NREG-1:0] wr_stb,
    output logic [7:0]      wr_data
);

    smb_evt_t evt;

    smb_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    smb_proto_fsm #(
        .NREG     (NREG),
        .SLV_ADDR (SLV_ADDR),
        .RO_MASK  (RO_MASK)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .sda_oe  (sda_oe),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .wr_stb  (wr_stb),
        .wr_data (wr_data)
    );

endmodule

// File: tb/smb_reg_slave_test.sv
module smb_reg_slave_test;

    localparam int         NREG = 18;
    localparam logic [6:0] ADR  = 7'h69;
    localparam int         Q    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_line;
    logic [4:0] rd_idx;
    logic [7:0] rd_data;
    logic [NREG-1:0] wr_stb;
    logic [7:0] wr_data;

    logic [7:0] mdl  [NREG];
    logic [7:0] expv [NREG];
    int exp_q[$];
    int checks = 0;
    int fails = 0;
    int r13_viol = 0;
    logic prev_scl = 1'b1;
    logic prev_oe = 1'b0;
    bit done = 0;

    assign sda_line = m_sda & ~sda_oe;
    assign rd_data  = (rd_idx < NREG) ? mdl[rd_idx] : 8'h00;

    smb_reg_slave #(.NREG(NREG), .SLV_ADDR(ADR)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_stb(wr_stb), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model: queue of expected writes, compared every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_stb != '0) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R10 R11 unexpected strobe", int'(wr_stb), 0);
                end else begin
                    automatic int e = exp_q.pop_front();
                    automatic int idx = -1;
                    for (int i = 0; i < NREG; i++) if (wr_stb[i]) idx = i;
                    chk($countones(wr_stb) == 1 && idx == e / 256 && int'(wr_data) == e % 256,
                        "R4 strobe index/data", idx * 256 + int'(wr_data), e);
                    if (idx >= 0) mdl[idx] = wr_data;
                end
            end
            if (m_scl && prev_scl && sda_oe != prev_oe) r13_viol++;
        end
        prev_scl = m_scl;
        prev_oe  = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic wbit(input bit b);
        m_sda = b; tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic rbit(output bit b);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send(input logic [7:0] v, input bit exp_ack, input string tag);
        bit b;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(b);
        chk(b == !exp_ack, tag, int'(b), int'(!exp_ack));
    endtask

    task automatic recv(input logic [7:0] ev, input bit ack, input string tag);
        logic [7:0] v;
        bit b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        chk(v == ev, tag, int'(v), int'(ev));
        wbit(!ack);
    endtask

    task automatic expect_wr(input int idx, input logic [7:0] val);
        exp_q.push_back(idx * 256 + int'(val));
        expv[idx] = val;
    endtask

    task automatic drained(input string tag);
        tick(Q);
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    task automatic read_at(input logic [7:0] off, input logic [7:0] ev, input string tag);
        bus_start();
        send({ADR, 1'b0}, 1, "R2 addr ack");
        send({1'b1, off[6:0]}, 1, "R3 indexed cmd ack");
        bus_start();
        send({ADR, 1'b1}, 1, "R7 read addr ack");
        recv(ev, 0, tag);
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin
            mdl[i]  = 8'(8'h40 + i);
            expv[i] = 8'(8'h40 + i);
        end
        tick(5);
        rst_n = 1'b1;
        tick(5);
        chk(sda_oe == 1'b0, "R1 line released after reset", int'(sda_oe), 0);
        chk(wr_stb == '0, "R1 no strobe after reset", int'(wr_stb), 0);

        // R4 byte write
        bus_start();
        send({ADR, 1'b0}, 1, "R2 own address ack");
        send(8'h83, 1, "R3 indexed cmd ack");
        expect_wr(3, 8'hA5);
        send(8'hA5, 1, "R4 data ack");
        bus_stop();
        drained("R4 byte write strobed");

        // R7 byte read
        read_at(8'd3, 8'hA5, "R7 byte read");

        // R5 word write, R8 word read
        bus_start();
        send({ADR, 1'b0}, 1, "R2 addr ack");
        send(8'h8A, 1, "R3 cmd ack");
        expect_wr(10, 8'h5A);
        send(8'h5A, 1, "R5 low byte ack");
        expect_wr(11, 8'hC3);
        send(8'hC3, 1, "R5 high byte ack");
        bus_stop();
        drained("R5 word write strobes");
        bus_start();
        send({ADR, 1'b0}, 1, "R2 addr ack");
        send(8'h8A, 1, "R3 cmd ack");
        bus_start();
        send({ADR, 1'b1}, 1, "R8 read addr ack");
        recv(8'h5A, 1, "R8 word low");
        recv(8'hC3, 0, "R8 word high");
        bus_stop();

        // R6 block write, then a partial one ended by stop
        bus_start();
        send({ADR, 1'b0}, 1, "R2 addr ack");
        send(8'h00, 1, "R3 block cmd ack");
        send(8'h04, 1, "R6 count ack");
        expect_wr(0, 8'h11); send(8'h11, 1, "R6 block data ack");
        expect_wr(1, 8'h22); send(8'h22, 1, "R6 block data ack");
        expect_wr(2, 8'h33); send(8'h33, 1, "R6 block data ack");
        expect_wr(3, 8'h44); send(8'h44, 1, "R6 block data ack");
        bus_stop();
        drained("R6 block write strobes");
        bus_start();
        send({ADR, 1'b0}, 1, "R2 addr ack");
        send(8'h00, 1, "R3 block cmd ack");
        send(8'h05, 1, "R6 count ack");
        expect_wr(0, 8'h77); send(8'h77, 1, "R6 partial data ack");
        expect_wr(1, 8'h88); send(8'h88, 1, "R6 partial data ack");
        bus_stop();
        drained("R6 early stop strobes");

        // R9 block read
        bus_start();
        send({ADR, 1'b0}, 1, "R2 addr ack");
        send(8'h00, 1, "R3 block cmd ack");
        bus_start();
        send({ADR, 1'b1}, 1, "R9 read addr ack");
        recv(8'(NREG), 1, "R9 count byte");
        for (int i = 0; i < 6; i++) recv(expv[i], i < 5, "R9 block data");
        chk(sda_oe == 1'b0, "R9 released after nack", int'(sda_oe), 0);
        bus_stop();

        // R2 foreign address, write and read direction
        bus_start();
        send({7'h22, 1'b0}, 0, "R2 foreign address nack");
        send(8'h83, 0, "R2 ignored cmd");
        send(8'h99, 0, "R2 ignored data");
        bus_stop();
        drained("R2 no strobe on foreign address");
        bus_start();
        send({7'h22, 1'b1}, 0, "R2 foreign read nack");
        recv(8'hFF, 0, "R2 line not driven");
        bus_stop();

        // R3 block command with offset bits
        bus_start();
        send({ADR, 1'b0}, 1, "R2 addr ack");
        send(8'h05, 0, "R3 nonzero block offset nack");
        send(8'h12, 0, "R3 ignored after bad cmd");
        bus_stop();
        drained("R3 no strobe after bad cmd");

        // R10 read-only offset
        bus_start();
        send({ADR, 1'b0}, 1, "R2 addr ack");
        send(8'h85, 1, "R3 cmd ack");
        send(8'hEE, 1, "R10 read-only write ack");
        bus_stop();
        drained("R10 no strobe");
        read_at(8'd5, expv[5], "R10 read-only unchanged");

        // R11 out of range
        bus_start();
        send({ADR, 1'b0}, 1, "R2 addr ack");
        send(8'h94, 1, "R3 cmd ack");
        send(8'h5C, 1, "R11 out-of-range write ack");
        bus_stop();
        drained("R11 no strobe");
        read_at(8'd20, 8'hFF, "R11 out-of-range read");
        bus_start();
        send({ADR, 1'b0}, 1, "R2 addr ack");
        send(8'h91, 1, "R3 cmd ack");
        bus_start();
        send({ADR, 1'b1}, 1, "R8 read addr ack");
        recv(expv[17], 1, "R11 last register");
        recv(8'hFF, 0, "R11 past end");
        bus_stop();

        // R12 restart after command, abort inside address
        bus_start();
        send({ADR, 1'b0}, 1, "R2 addr ack");
        send(8'h82, 1, "R3 cmd ack");
        bus_start();
        send({ADR, 1'b0}, 1, "R12 addr ack after restart");
        send(8'h86, 1, "R12 cmd ack after restart");
        expect_wr(6, 8'h3C);
        send(8'h3C, 1, "R12 data ack");
        bus_stop();
        drained("R12 restart write");
        bus_start();
        wbit(1'b1); wbit(1'b1); wbit(1'b0);
        bus_stop();
        chk(sda_oe == 1'b0, "R12 idle after stop", int'(sda_oe), 0);
        bus_start();
        send({ADR, 1'b0}, 1, "R12 addr ack after abort");
        send(8'h87, 1, "R3 cmd ack");
        expect_wr(7, 8'h7E);
        send(8'h7E, 1, "R12 data ack after abort");
        bus_stop();
        drained("R12 write after abort");
        bus_start();
        send({ADR, 1'b0}, 1, "R2 addr ack");
        send(8'h86, 1, "R3 cmd ack");
        bus_start();
        send({ADR, 1'b1}, 1, "R8 read addr ack");
        recv(8'h3C, 1, "R12 readback 6");
        recv(8'h7E, 0, "R12 readback 7");
        bus_stop();

        chk(r13_viol == 0, "R13 line steady while clock high", r13_viol, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule